// File: doc/BRIEF.md
# Mode-Controlled Three-Bit Shift Register

This block is a three-bit register whose contents are rewritten on every rising clock edge according to a two-bit operation code. The four operations are: keep the current value, shift toward the least significant end with a zero entering at the top, rotate toward the most significant end, and take a parallel word from the data inputs. Each bit's next value comes from its own four-input selector, indexed by the operation code. The selector inputs are the bit itself, a neighbouring bit, a constant or the matching data input.

A synchronous, active-high reset clears the register. The reset wins over whatever operation code is present in the same cycle. The outputs show the register directly, so a result appears one clock edge after the code that caused it. Between edges the outputs do not change.

Top module: `tri_bit_mode_shifter`

## Requirements
- R1: When `rst` is 1 at a rising edge, `word_out` is 3'b000 after that edge.
- R2: Reset takes priority over every operation code: `rst`=1 with `op_sel`=2'b11 and a nonzero `par_in` still leaves `word_out`=3'b000.
- R3: With `rst`=0 and `op_sel`=2'b00, `word_out` keeps its previous value across the edge.
- R4: With `rst`=0 and `op_sel`=2'b01, the new value is {1'b0, old[2], old[1]}: bit 2 receives 0, bit 1 the old bit 2, bit 0 the old bit 1.
- R5: With `rst`=0 and `op_sel`=2'b10, the new value is {old[1], old[0], old[2]}: every bit moves one place toward bit 2 and bit 0 receives the old bit 2.
- R6: With `rst`=0 and `op_sel`=2'b11, `word_out` takes `par_in` after the edge, with bit i of `par_in` going to bit i of `word_out`.
- R7: Under `op_sel` codes 2'b00, 2'b01 and 2'b10, the value of `par_in` has no effect on `word_out`.
- R8: `word_out` changes only at a rising edge of `clk`. Input changes between edges do not show on it until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | Operation code: 00 keep, 01 shift down, 10 rotate up, 11 load |
| par_in | input | 3 | Parallel data word for the load operation |
| word_out | output | 3 | Register contents |

## Verification
The two functions that can land in the same cycle are reset and parallel load. A register that lets the load leak past the reset is the interesting failure. The bench drives `rst` high together with code 2'b11 and a nonzero data word. It expects all zeros after the edge, and it also expects zeros after reset combined with every other code. Separately, `par_in` keeps changing while the other three codes run. Any trace of it in the output is judged against the model's value, which ignores the data word.

// File: rtl/tbms_pkg.sv
package tbms_pkg;
    localparam int NBITS = 3;
    localparam int OPW   = 2;
    localparam int NCAND = 1 << OPW;

    typedef enum logic [OPW-1:0] {
        OP_KEEP = 2'b00,
        OP_SHR  = 2'b01,
        OP_ROTL = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

    typedef struct packed {
        logic [NBITS-1:0] word;
    } state_t;
endpackage

// File: rtl/tbms_mux4.sv
module tbms_mux4
    import tbms_pkg::*;
(
    input  logic [NCAND-1:0] cand,
    input  logic [OPW-1:0]   sel,
    output logic             y
);
    always_comb begin
        y = cand[sel];
    end
endmodule

// File: rtl/tbms_next_logic.sv
module tbms_next_logic
    import tbms_pkg::*;
(
    input  logic [NBITS-1:0] cur,
    input  logic [NBITS-1:0] par_in,
    input  logic [OPW-1:0]   op,
    output logic [NBITS-1:0] nxt
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [NCAND-1:0] cand;
        logic             from_above;
        logic             from_below;

        // Source for a shift toward bit 0: the bit above, or zero at the top.
        if (b == NBITS - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_mid_hi
            assign from_above = cur[b+1];
        end

        // Source for a rotation toward the top: the bit below, or the top bit wrapped.
        if (b == 0) begin : g_bottom
            assign from_below = cur[NBITS-1];
        end else begin : g_mid_lo
            assign from_below = cur[b-1];
        end

        always_comb begin
            cand          = '0;
            cand[OP_KEEP] = cur[b];
            cand[OP_SHR]  = from_above;
            cand[OP_ROTL] = from_below;
            cand[OP_LOAD] = par_in[b];
        end

        tbms_mux4 u_mux (
            .cand (cand),
            .sel  (op),
            .y    (nxt[b])
        );
    end
endmodule

// File: rtl/tri_bit_mode_shifter.sv
module tri_bit_mode_shifter
    import tbms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   op_sel,
    input  logic [NBITS-1:0] par_in,
    output logic [NBITS-1:0] word_out
);
    state_t           st_d;
    state_t           st_q;
    logic [NBITS-1:0] sel_word;

    tbms_next_logic u_next (
        .cur    (st_q.word),
        .par_in (par_in),
        .op     (op_sel),
        .nxt    (sel_word)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.word = '0;
        end else begin
            st_d.word = sel_word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word_out = st_q.word;
endmodule

// File: rtl/tbms_checker.sv
module tbms_checker
    import tbms_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPW-1:0]   op_sel,
    input logic [NBITS-1:0] par_in,
    input logic [NBITS-1:0] word_out
);
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // R1 and R2: a reset edge leaves zeros whatever the code
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!armed_q)
        rst |=> (word_out == '0));

    p_reset_over_load_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (rst && op_sel == OP_LOAD) |=> (word_out == '0));

    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_KEEP) |=> $stable(word_out));

    p_shift_down_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SHR) |=> (word_out == {1'b0, $past(word_out[NBITS-1:1])}));

    p_rotate_up_r5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ROTL) |=> (word_out == {$past(word_out[NBITS-2:0]), $past(word_out[NBITS-1])}));

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_LOAD) |=> (word_out == $past(par_in)));
endmodule

bind tri_bit_mode_shifter tbms_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .par_in   (par_in),
    .word_out (word_out)
);

// File: tb/tri_bit_mode_shifter_test.sv
`timescale 1ns/1ps
module tri_bit_mode_shifter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_sel = 2'b00;
    logic [2:0] par_in = 3'b000;
    logic [2:0] word_out;

    int checks = 0;
    int failures = 0;
    int expv = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tri_bit_mode_shifter uut (
        .clk      (clk),
        .rst      (rst),
        .op_sel   (op_sel),
        .par_in   (par_in),
        .word_out (word_out)
    );

    task automatic check(input string tag, input int expected);
        checks++;
        if (int'(word_out) != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, word_out, expected, $time);
        end
    endtask

    // Behavioural reference for one edge.
    function automatic int model(input int cur, input bit r, input int op, input int d);
        if (r) return 0;
        case (op)
            0: return cur;
            1: return cur / 2;
            2: return ((cur * 2) + (cur / 4)) % 8;
            default: return d;
        endcase
    endfunction

    task automatic step(input bit r, input int op, input int d);
        string tag;
        @(negedge clk);
        rst = r;
        op_sel = op[1:0];
        par_in = d[2:0];
        #1;
        check("R8", expv);           // inputs changed, output must not have moved
        expv = model(expv, r, op, d);
        if (r && op == 3)    tag = "R2";
        else if (r)          tag = "R1";
        else if (op == 0)    tag = "R3/R7";
        else if (op == 1)    tag = "R4/R7";
        else if (op == 2)    tag = "R5/R7";
        else                 tag = "R6";
        @(posedge clk);
        #1;
        check(tag, expv);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        check("R1", 0);              // reset state
        step(0, 3, 5);               // R6 load 101
        step(0, 2, 2);               // R5 rotate: 101 -> 011
        step(0, 2, 7);               // R5 -> 110
        step(0, 2, 0);               // R5 wrap -> 101
        step(0, 0, 6);               // R3 hold with other data, R7
        step(0, 1, 7);               // R4 -> 010
        step(0, 1, 7);               // R4 -> 001
        step(0, 1, 0);               // R4 -> 000
        step(0, 3, 7);               // R6 load 111
        step(1, 3, 6);               // R2 reset beats load
        step(0, 3, 4);               // R6 load 100
        step(0, 2, 1);               // R5 top wraps -> 001
        step(1, 2, 7);               // R1 reset with rotate
        step(0, 3, 3);
        step(1, 1, 5);               // R1 reset with shift
        step(0, 3, 6);
        step(1, 0, 5);               // R1 reset with hold
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 16) == 0, $urandom % 4, $urandom % 8);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule